// File: doc/BRIEF.md
# Layer Alpha Compositing Stage

This block mixes one display layer's pixel stream over a background pixel stream, one pixel per handshake. Each layer pixel arrives with its colour channels, an alpha field and a code telling how wide that alpha field is: absent, 1 bit, 2 bits or a full 8 bits. Short alpha fields are widened through a programmable lookup word that holds four 8-bit entries. A layer control word selects one of three blends:
- a constant alpha for the whole layer,
- the per-pixel alpha,
- the per-pixel alpha with colour that is already premultiplied.

The control word and the lookup word are taken in only on a frame-start strobe, so writing them in the middle of a frame never tears a frame. The datapath is a two-stage pipeline with valid/ready on both sides. The first stage resolves the alpha value and the kind of blend. The second stage does the per-channel arithmetic and holds the output register.

Top module: `layer_blend_stage`

## Requirements
- R1: While bit 0 (enable) of the active control word is 0, each output pixel equals the background pixel accepted with it.
- R2: With the mode field (control bits 13:12) equal to 2, each channel uses the constant alpha a from control bits 23:16: out = (a*L + (255-a)*B + 127) / 255. The alpha field and the premultiply bit have no effect in this mode.
- R3: With mode 3 and the premultiply bit (control bit 14) clear, each channel is blended with the same formula using the widened pixel alpha.
- R4: With mode 3 and bit 14 set, each channel is out = L + ((255-a)*B + 127) / 255, saturated at 255.
- R5: Alpha widening depends on the alpha format code.
  - Code 1 (1 bit): the lowest alpha bit selects lookup bits 7:0 when it is 0 and bits 31:24 when it is 1.
  - Code 2 (2 bits): value n in alpha bits 1:0 selects lookup bits 8n+7:8n.
  - Code 3: the 8-bit alpha is used as it is.
- R6: With mode 3 and alpha format code 0 (no alpha channel), or with mode 0 or 1, an enabled layer outputs the layer pixel unchanged.
- R7: The control and lookup words take effect only at a clock edge where frameStart is high. Changes at other times have no effect. After reset the layer is disabled and the lookup word is 0xFFAA5500.
- R8: A pixel accepted at one edge appears on the output after the next edge when outReady is high. While outValid is high and outReady is low, outValid and outPixel hold.
- R9: inReady is high whenever the output register is empty.

Pixels pack channel i in bits 8i+7:8i of the 24-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Loads ctrlIn and lutIn into the active configuration |
| ctrlIn | input | 32 | Layer control word (pending) |
| lutIn | input | 32 | Alpha lookup word, four 8-bit entries (pending) |
| layerValid | input | 1 | Layer/background pixel pair is valid |
| inReady | output | 1 | Block accepts a pixel pair this cycle |
| layerPixel | input | 24 | Layer colour |
| layerAlpha | input | 8 | Layer alpha field, low bits used for short formats |
| alphaFmt | input | 2 | Alpha width code: 0 none, 1 one bit, 2 two bits, 3 eight bits |
| bgPixel | input | 24 | Background colour |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the output pixel |
| outPixel | output | 24 | Composited colour |

## Verification
A pixel pair accepted at edge E loads the first stage at E. It reaches the output register at E+1 if that register is empty or drained at E+1, and later if it is stalled. The bench therefore never predicts a fixed cycle for a result. It pushes the expected pixel into an ordered queue at the acceptance edge, using the configuration modelled at that moment. It pops and compares the queue only at cycles where outValid and outReady are both high, sampling half a cycle after the edge. The fixed one-edge latency and the hold under stall are checked in a directed segment that counts edges from an empty pipeline.

// File: rtl/layer_blend_pkg.sv
package layer_blend_pkg;

  // position of fields inside the layer control word
  localparam int ENABLE_BIT  = 0;
  localparam int MODE_LSB    = 12;
  localparam int PREMUL_BIT  = 14;
  localparam int PALPHA_LSB  = 16;

  localparam logic [1:0] MODE_PLANE = 2'd2;
  localparam logic [1:0] MODE_PIXEL = 2'd3;

  localparam logic [1:0] AFMT_NONE = 2'd0;
  localparam logic [1:0] AFMT_ONE  = 2'd1;
  localparam logic [1:0] AFMT_TWO  = 2'd2;

  typedef enum logic [1:0] {
    KIND_BG     = 2'd0,
    KIND_LAYER  = 2'd1,
    KIND_MIX    = 2'd2,
    KIND_PREMIX = 2'd3
  } blendKind_e;

  typedef struct packed {
    logic       enable;
    logic [1:0] mode;
    logic       premul;
  } layerCfg_t;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } pipeStrobe_t;

endpackage

// File: rtl/layer_blend_ctrl.sv
module layer_blend_ctrl
  import layer_blend_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int CTRL_W = 32,
  parameter logic [4*CH_W-1:0] LUT_RESET = 32'hFFAA5500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic [4*CH_W-1:0] lutIn,
  input  logic              layerValid,
  input  logic              outReady,
  output layerCfg_t         activeCfg,
  output logic [CH_W-1:0]   activeAlpha,
  output logic [4*CH_W-1:0] activeLut,
  output pipeStrobe_t       strobe,
  output logic              inReady,
  output logic              outValid
);

  logic s1Valid;
  logic s2Free;
  logic s1Free;

  always_comb begin
    s2Free = !outValid || outReady;
    s1Free = !s1Valid || s2Free;
    inReady = s1Free;
    strobe.s1Load = layerValid && s1Free;
    strobe.s2Load = s1Valid && s2Free;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (s1Free) s1Valid <= layerValid;
      if (s2Free) outValid <= s1Valid;
    end
  end

  // configuration shadow: only the frame-start strobe updates it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCfg <= '0;
      activeAlpha <= '0;
      activeLut <= LUT_RESET;
    end else if (frameStart) begin
      activeCfg.enable <= ctrlIn[ENABLE_BIT];
      activeCfg.mode <= ctrlIn[MODE_LSB +: 2];
      activeCfg.premul <= ctrlIn[PREMUL_BIT];
      activeAlpha <= ctrlIn[PALPHA_LSB +: CH_W];
      activeLut <= lutIn;
    end
  end

endmodule

// File: rtl/layer_blend_datapath.sv
module layer_blend_datapath
  import layer_blend_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pipeStrobe_t            strobe,
  input  layerCfg_t              activeCfg,
  input  logic [CH_W-1:0]        activeAlpha,
  input  logic [4*CH_W-1:0]      activeLut,
  input  logic [NUM_CH*CH_W-1:0] layerPixel,
  input  logic [CH_W-1:0]        layerAlpha,
  input  logic [1:0]             alphaFmt,
  input  logic [NUM_CH*CH_W-1:0] bgPixel,
  output logic [NUM_CH*CH_W-1:0] outPixel
);

  localparam int PIX_W = NUM_CH * CH_W;
  localparam int MAXV = (1 << CH_W) - 1;
  localparam int HALF = MAXV / 2;
  localparam int PROD_W = 2 * CH_W + 2;

  // stage 1: resolve alpha and blend kind
  logic [CH_W-1:0] pixAlpha;
  logic [CH_W-1:0] selAlpha;
  blendKind_e kindNext;

  always_comb begin
    unique case (alphaFmt)
      AFMT_NONE: pixAlpha = CH_W'(MAXV);
      AFMT_ONE:  pixAlpha = layerAlpha[0] ? activeLut[3*CH_W +: CH_W] : activeLut[0 +: CH_W];
      AFMT_TWO:  pixAlpha = activeLut[layerAlpha[1:0]*CH_W +: CH_W];
      default:   pixAlpha = layerAlpha;
    endcase
  end

  always_comb begin
    selAlpha = pixAlpha;
    kindNext = KIND_LAYER;
    if (!activeCfg.enable) begin
      kindNext = KIND_BG;
    end else if (activeCfg.mode == MODE_PLANE) begin
      kindNext = KIND_MIX;
      selAlpha = activeAlpha;
    end else if (activeCfg.mode == MODE_PIXEL && alphaFmt != AFMT_NONE) begin
      kindNext = activeCfg.premul ? KIND_PREMIX : KIND_MIX;
    end
  end

  blendKind_e s1Kind;
  logic [CH_W-1:0] s1Alpha;
  logic [PIX_W-1:0] s1Layer;
  logic [PIX_W-1:0] s1Bg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Kind <= KIND_BG;
      s1Alpha <= '0;
      s1Layer <= '0;
      s1Bg <= '0;
    end else if (strobe.s1Load) begin
      s1Kind <= kindNext;
      s1Alpha <= selAlpha;
      s1Layer <= layerPixel;
      s1Bg <= bgPixel;
    end
  end

  // stage 2: per-channel arithmetic
  logic [PIX_W-1:0] mixed;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [PROD_W-1:0] lv, bv, av, inv;
    logic [PROD_W-1:0] mixSum, mixQ, pmSum, pmQ, pmTot;
    logic [CH_W-1:0] chOut;

    always_comb begin
      lv = PROD_W'(s1Layer[ch*CH_W +: CH_W]);
      bv = PROD_W'(s1Bg[ch*CH_W +: CH_W]);
      av = PROD_W'(s1Alpha);
      inv = PROD_W'(MAXV) - av;
      mixSum = av * lv + inv * bv + PROD_W'(HALF);
      mixQ = mixSum / PROD_W'(MAXV);
      pmSum = inv * bv + PROD_W'(HALF);
      pmQ = pmSum / PROD_W'(MAXV);
      pmTot = lv + pmQ;
      unique case (s1Kind)
        KIND_BG:    chOut = s1Bg[ch*CH_W +: CH_W];
        KIND_LAYER: chOut = s1Layer[ch*CH_W +: CH_W];
        KIND_MIX:   chOut = mixQ[CH_W-1:0];
        default:    chOut = (pmTot > PROD_W'(MAXV)) ? CH_W'(MAXV) : pmTot[CH_W-1:0];
      endcase
    end

    assign mixed[ch*CH_W +: CH_W] = chOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outPixel <= '0;
    else if (strobe.s2Load) outPixel <= mixed;
  end

endmodule

// File: rtl/layer_blend_stage.sv
module layer_blend_stage
  import layer_blend_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int NUM_CH = 3,
  parameter int CTRL_W = 32,
  parameter logic [4*CH_W-1:0] LUT_RESET = 32'hFFAA5500
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  input  logic [CTRL_W-1:0]      ctrlIn,
  input  logic [4*CH_W-1:0]      lutIn,
  input  logic                   layerValid,
  output logic                   inReady,
  input  logic [NUM_CH*CH_W-1:0] layerPixel,
  input  logic [CH_W-1:0]        layerAlpha,
  input  logic [1:0]             alphaFmt,
  input  logic [NUM_CH*CH_W-1:0] bgPixel,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [NUM_CH*CH_W-1:0] outPixel
);

  layerCfg_t activeCfg;
  logic [CH_W-1:0] activeAlpha;
  logic [4*CH_W-1:0] activeLut;
  pipeStrobe_t strobe;

  layer_blend_ctrl #(.CH_W(CH_W), .CTRL_W(CTRL_W), .LUT_RESET(LUT_RESET)) ctrlUnit (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .ctrlIn(ctrlIn), .lutIn(lutIn),
    .layerValid(layerValid), .outReady(outReady), .activeCfg(activeCfg),
    .activeAlpha(activeAlpha), .activeLut(activeLut), .strobe(strobe),
    .inReady(inReady), .outValid(outValid)
  );

  layer_blend_datapath #(.CH_W(CH_W), .NUM_CH(NUM_CH)) dataUnit (
    .clk(clk), .rstN(rstN), .strobe(strobe), .activeCfg(activeCfg),
    .activeAlpha(activeAlpha), .activeLut(activeLut), .layerPixel(layerPixel),
    .layerAlpha(layerAlpha), .alphaFmt(alphaFmt), .bgPixel(bgPixel), .outPixel(outPixel)
  );

endmodule

// File: rtl/layer_blend_checker.sv
module layer_blend_checker
  import layer_blend_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int CH_W = 8,
  parameter int LUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic             layerValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPixel,
  input layerCfg_t        activeCfg,
  input logic [CH_W-1:0]  activeAlpha,
  input logic [LUT_W-1:0] activeLut
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPixel)); // R8

  AST_ONE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (layerValid && inReady) ##1 outReady |=> outValid); // R8

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady); // R9

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeCfg) && $stable(activeAlpha)); // R7

  AST_LUT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeLut)); // R7

endmodule

bind layer_blend_stage layer_blend_checker #(.PIX_W(NUM_CH*CH_W), .CH_W(CH_W), .LUT_W(4*CH_W)) chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .layerValid(layerValid),
  .inReady(inReady), .outValid(outValid), .outReady(outReady), .outPixel(outPixel),
  .activeCfg(activeCfg), .activeAlpha(activeAlpha), .activeLut(activeLut)
);

// File: tb/layer_blend_stage_test.sv
module layer_blend_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic [31:0] ctrlIn = '0;
  logic [31:0] lutIn = '0;
  logic layerValid = 1'b0;
  logic inReady;
  logic [23:0] layerPixel = '0;
  logic [7:0] layerAlpha = '0;
  logic [1:0] alphaFmt = '0;
  logic [23:0] bgPixel = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [23:0] outPixel;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_blend_stage uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .ctrlIn(ctrlIn), .lutIn(lutIn),
    .layerValid(layerValid), .inReady(inReady), .layerPixel(layerPixel),
    .layerAlpha(layerAlpha), .alphaFmt(alphaFmt), .bgPixel(bgPixel),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] modelCtrl = 32'h0;
  logic [31:0] modelLut = 32'hFFAA5500;
  logic [23:0] expQ[$];
  string tagQ[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] widen(logic [31:0] lut, logic [1:0] fmt, logic [7:0] raw);
    case (fmt)
      2'd0: return 8'hFF;
      2'd1: return raw[0] ? lut[31:24] : lut[7:0];
      2'd2: return lut[8*raw[1:0] +: 8];
      default: return raw;
    endcase
  endfunction

  function automatic logic [23:0] model(logic [31:0] c, logic [31:0] lut, logic [23:0] l,
                                        logic [23:0] b, logic [1:0] fmt, logic [7:0] raw);
    int a;
    int pm;
    logic [23:0] r;
    if (!c[0]) return b;
    if (c[13:12] == 2'd2) begin a = c[23:16]; pm = 0; end
    else if (c[13:12] == 2'd3 && fmt != 2'd0) begin a = widen(lut, fmt, raw); pm = c[14]; end
    else return l;
    for (int ch = 0; ch < 3; ch++) begin
      int lc = l[8*ch +: 8];
      int bc = b[8*ch +: 8];
      int v;
      if (pm != 0) begin
        v = lc + ((255 - a) * bc + 127) / 255;
        if (v > 255) v = 255;
      end else v = (a * lc + (255 - a) * bc + 127) / 255;
      r[8*ch +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic string tagOf(logic [31:0] c, logic [1:0] fmt);
    if (!c[0]) return "R1";
    if (c[13:12] == 2'd2) return "R2";
    if (c[13:12] != 2'd3 || fmt == 2'd0) return "R6";
    if (c[14]) return "R4";
    return (fmt == 2'd3) ? "R3" : "R5";
  endfunction

  // one cycle: drive after the falling edge, account for the coming rising edge
  task automatic cycle(bit lv, logic [23:0] lp, logic [7:0] la, logic [1:0] af,
                       logic [23:0] bp, bit ordy, bit fs, logic [31:0] ci, logic [31:0] li);
    @(negedge clk);
    layerValid = lv; layerPixel = lp; layerAlpha = la; alphaFmt = af; bgPixel = bp;
    outReady = ordy; frameStart = fs; ctrlIn = ci; lutIn = li;
    #1;
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R8", {8'h0, outPixel}, 32'h0);
      else begin
        logic [23:0] e = expQ.pop_front();
        string t = tagQ.pop_front();
        check(outPixel == e, t, {8'h0, outPixel}, {8'h0, e});
      end
    end
    if (lv && inReady) begin
      expQ.push_back(model(modelCtrl, modelLut, lp, bp, af, la));
      tagQ.push_back(tagOf(modelCtrl, af));
    end
    if (fs) begin modelCtrl = ci; modelLut = li; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 1, 0, ctrlIn, lutIn);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R8", {31'h0, outValid}, 32'h0);
    check(inReady == 1'b1, "R9", {31'h0, inReady}, 32'h1);

    // R7 and R1: reset configuration is disabled, background passes
    cycle(1, 24'h123456, 8'hFF, 2'd3, 24'hABCDEF, 1, 0, 32'h0000_3001, 32'h0);
    // R8: latency counted from an empty pipeline
    @(negedge clk); layerValid = 0; #1;
    check(outValid == 1'b0, "R8", {31'h0, outValid}, 32'h0);
    idle(1);
    idle(2);

    // R2: plane alpha 0x80 with pixel alpha ignored
    cycle(0, 0, 0, 0, 0, 1, 1, 32'h0080_6001, 32'hFFAA5500);
    cycle(1, 24'hFFFFFF, 8'h00, 2'd3, 24'h000000, 1, 0, 32'h0, 32'h0);
    cycle(1, 24'h10F080, 8'h33, 2'd1, 24'h806040, 1, 0, 32'h0, 32'h0);
    // R5: short alpha codes through the default table
    cycle(0, 0, 0, 0, 0, 1, 1, 32'h0000_3001, 32'hFFAA5500);
    cycle(1, 24'hFFFFFF, 8'h01, 2'd1, 24'h000000, 1, 0, 32'h0, 32'h0);
    cycle(1, 24'hFFFFFF, 8'hFE, 2'd1, 24'h102030, 1, 0, 32'h0, 32'h0);
    cycle(1, 24'hFFFFFF, 8'h01, 2'd2, 24'h000000, 1, 0, 32'h0, 32'h0);
    cycle(1, 24'hFFFFFF, 8'h02, 2'd2, 24'h000000, 1, 0, 32'h0, 32'h0);
    // R6: no alpha channel, layer passes
    cycle(1, 24'h5A5A5A, 8'h00, 2'd0, 24'h000000, 1, 0, 32'h0, 32'h0);
    // R4: premultiplied, saturation and plain case
    cycle(0, 0, 0, 0, 0, 1, 1, 32'h0000_7001, 32'h12345678);
    cycle(1, 24'hFFFFFF, 8'h00, 2'd3, 24'hFFFFFF, 1, 0, 32'h0, 32'h0);
    cycle(1, 24'h101010, 8'h80, 2'd3, 24'h202020, 1, 0, 32'h0, 32'h0);
    // R7: mid-frame control changes ignored
    cycle(1, 24'hC0C0C0, 8'h40, 2'd3, 24'h404040, 1, 0, 32'h0000_0000, 32'h0);
    idle(3);

    // R8: hold under stall
    cycle(1, 24'h336699, 8'h77, 2'd3, 24'h996633, 0, 0, 32'h0, 32'h0);
    cycle(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    cycle(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    held = outPixel;
    check(outValid == 1'b1, "R8", {31'h0, outValid}, 32'h1);
    cycle(0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    check(outValid == 1'b1 && outPixel == held, "R8", {8'h0, outPixel}, {8'h0, held});
    idle(3);

    // random traffic with random stalls and frame strobes
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [31:0] c;
      c = $urandom;
      c[0] = ($urandom % 5) != 0;
      cycle(($urandom % 4) != 0, 24'($urandom), 8'($urandom), 2'($urandom), 24'($urandom),
            ($urandom % 4) != 0, ($urandom % 12) == 0, c, $urandom);
    end
    idle(5);
    check(expQ.size() == 0, "R8", expQ.size(), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule